// File: doc/BRIEF.md
# Predicated Cross-Segment Minimum-Number Reduction

This unit takes a scalable vector, cut into 128-bit segments, and folds the segments onto each other. For every element position inside a segment, the elements at that position in all segments are combined with the IEEE minimum-number rule. The result for lane e is written to lane e of a 128-bit output. Elements can be 16, 32 or 64 bits wide, chosen per operation by a size code.

A byte-granular predicate travels with the vector. An element whose predicate is clear does not use its data. It enters the reduction as the default NaN, which is the neutral value for minimum-number.

The fold is a binary tree that pairs neighbours first. Each level of the tree is registered. A new operation may start on every cycle. Each operation ends with a one-cycle done pulse that carries the result and an invalid-operation flag. The unit is meant to sit behind a vector register read port as one pipelined execution resource.

Top module: `segmin_reduce`

## Requirements
- R1: Lane e of `result`, at bits [e*W +: W], is the minimum-number of element e of every segment. Segment s occupies `vec[128*s +: 128]`. W is 16 for size code 01, 32 for size code 10 and 64 for size code 11.
- R2: Element e of segment s is active when predicate bit `pred[16*s + e*W/8]` is 1. The other predicate bits of that element have no effect. An inactive element contributes the default NaN of its format: sign 0, exponent all ones, mantissa MSB 1 and the rest 0. That is 7E00, 7FC00000 or 7FF8000000000000.
- R3: A quiet NaN paired with a number yields the number. Negative zero is smaller than positive zero. Infinities order as usual.
- R4: Pairs are combined in a tree that joins neighbouring segments first, with the lower segment as the first operand. A pair that holds a signalling NaN, or two NaNs, yields a quiet NaN. With `dflt_nan`=0 that NaN is the first signalling operand made quiet, otherwise the first operand. With `dflt_nan`=1 it is the default NaN.
- R5: `invalid` is 1 with `done` when any pair in the operation held a signalling NaN. Otherwise it is 0.
- R6: `done` is a one-cycle pulse log2(VLEN/128)+1 cycles after the cycle in which `start` is high. Starts on consecutive cycles each give their own pulse, in order.
- R7: A `start` with size code 00 is dropped. No `done` follows, and `result` and `invalid` keep their values.
- R8: `result` and `invalid` hold their last values in every cycle without `done`.
- R9: When no element is active, every lane equals the default NaN and `invalid` is 0.
- R10: Reset clears `result`, `done` and `invalid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation on the inputs present this cycle |
| vec | input | VLEN | Source vector, segment s at bits [128*s +: 128] |
| pred | input | VLEN/8 | One predicate bit per vector byte |
| size | input | 2 | Element size code: 01=16, 10=32, 11=64 bits, 00 illegal |
| dflt_nan | input | 1 | 1: every NaN result is the default NaN |
| result | output | 128 | Reduced lanes |
| done | output | 1 | One-cycle pulse marking a new result |
| invalid | output | 1 | A signalling NaN was consumed by the operation |

## Verification
On every cycle the assertions check several things. `done` follows each legal start after exactly the pipeline depth and never follows an illegal one. `result` and `invalid` stay still between pulses. Every NaN lane in a completed result is quiet, and a NaN lane is canonical when default-NaN mode was requested. Only the bench scenarios can show the lane values themselves. Those scenarios cover the minimum ordering including signed zeros and infinities, the choice of which NaN propagates through the tree, the byte chosen to represent each element's predicate, and the correct mapping of segments onto lanes for all three element sizes.

// File: rtl/segmin_pkg.sv
package segmin_pkg;

    localparam int SEG_W  = 128;
    localparam int SEG_B  = SEG_W / 8;

    typedef enum logic [1:0] {
        SZ_BAD = 2'b00,
        SZ_H   = 2'b01,
        SZ_S   = 2'b10,
        SZ_D   = 2'b11
    } esz_e;

endpackage

// File: rtl/segmin_lane.sv
// One minimum-number comparator for a single element format.
module segmin_lane #(
    parameter int EW = 8,
    parameter int MW = 23,
    localparam int W = 1 + EW + MW
) (
    input  logic         dn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         inv
);

    localparam logic [W-1:0] DNAN = {1'b0, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};

    logic         a_nan, b_nan, a_sig, b_sig, a_lt;
    logic [W-2:0] a_mag, b_mag;

    always_comb begin
        a_nan = (&a[W-2:MW]) && (|a[MW-1:0]);
        b_nan = (&b[W-2:MW]) && (|b[MW-1:0]);
        a_sig = a_nan && !a[MW-1];
        b_sig = b_nan && !b[MW-1];
        a_mag = a[W-2:0];
        b_mag = b[W-2:0];
        if (a[W-1] != b[W-1]) a_lt = a[W-1];
        else if (a[W-1])      a_lt = a_mag > b_mag;
        else                  a_lt = a_mag < b_mag;

        inv = a_sig | b_sig;
        if (a_sig || b_sig || (a_nan && b_nan)) begin
            if (dn)         y = DNAN;
            else if (a_sig) y = {a[W-1:MW], 1'b1, a[MW-2:0]};
            else if (b_sig) y = {b[W-1:MW], 1'b1, b[MW-2:0]};
            else            y = a;
        end else if (a_nan) begin
            y = b;
        end else if (b_nan) begin
            y = a;
        end else begin
            y = a_lt ? a : b;
        end
    end

endmodule

// File: rtl/segmin_node.sv
// Combines two 128-bit segments lane by lane for the selected element size.
module segmin_node
    import segmin_pkg::*;
(
    input  esz_e             sz,
    input  logic             dn,
    input  logic [SEG_W-1:0] a,
    input  logic [SEG_W-1:0] b,
    output logic [SEG_W-1:0] y,
    output logic             inv
);

    localparam int NH = SEG_W / 16;
    localparam int NS = SEG_W / 32;
    localparam int ND = SEG_W / 64;

    logic [NH-1:0][15:0] yh;
    logic [NS-1:0][31:0] ys;
    logic [ND-1:0][63:0] yd;
    logic [NH-1:0]       ih;
    logic [NS-1:0]       is;
    logic [ND-1:0]       id;

    for (genvar i = 0; i < NH; i++) begin : g_h
        segmin_lane #(.EW(5), .MW(10)) u_lane (
            .dn(dn), .a(a[16*i +: 16]), .b(b[16*i +: 16]), .y(yh[i]), .inv(ih[i]));
    end
    for (genvar i = 0; i < NS; i++) begin : g_s
        segmin_lane #(.EW(8), .MW(23)) u_lane (
            .dn(dn), .a(a[32*i +: 32]), .b(b[32*i +: 32]), .y(ys[i]), .inv(is[i]));
    end
    for (genvar i = 0; i < ND; i++) begin : g_d
        segmin_lane #(.EW(11), .MW(52)) u_lane (
            .dn(dn), .a(a[64*i +: 64]), .b(b[64*i +: 64]), .y(yd[i]), .inv(id[i]));
    end

    always_comb begin
        case (sz)
            SZ_H:    begin y = yh; inv = |ih; end
            SZ_S:    begin y = ys; inv = |is; end
            SZ_D:    begin y = yd; inv = |id; end
            default: begin y = '0; inv = 1'b0; end
        endcase
    end

endmodule

// File: rtl/segmin_mask.sv
// Replaces inactive elements with the default NaN of the selected format.
module segmin_mask
    import segmin_pkg::*;
#(
    parameter int NSEG = 4
) (
    input  logic [NSEG*SEG_W-1:0]      vec,
    input  logic [NSEG*SEG_B-1:0]      pred,
    input  esz_e                       sz,
    output logic [NSEG-1:0][SEG_W-1:0] seg_o
);

    logic                       any_act;
    logic [NSEG*SEG_W-1:0]      vec_g;
    logic [NSEG-1:0][SEG_W-1:0] hv, sv, dv;

    // With nothing active the data never reaches the stage registers.
    assign any_act = |pred;
    assign vec_g   = any_act ? vec : '0;

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        for (genvar e = 0; e < SEG_W/16; e++) begin : g_h
            assign hv[s][16*e +: 16] = pred[s*SEG_B + 2*e]
                ? vec_g[s*SEG_W + 16*e +: 16] : 16'h7E00;
        end
        for (genvar e = 0; e < SEG_W/32; e++) begin : g_s
            assign sv[s][32*e +: 32] = pred[s*SEG_B + 4*e]
                ? vec_g[s*SEG_W + 32*e +: 32] : 32'h7FC0_0000;
        end
        for (genvar e = 0; e < SEG_W/64; e++) begin : g_d
            assign dv[s][64*e +: 64] = pred[s*SEG_B + 8*e]
                ? vec_g[s*SEG_W + 64*e +: 64] : 64'h7FF8_0000_0000_0000;
        end
    end

    always_comb begin
        case (sz)
            SZ_H:    seg_o = hv;
            SZ_S:    seg_o = sv;
            SZ_D:    seg_o = dv;
            default: seg_o = '0;
        endcase
    end

endmodule

// File: rtl/segmin_level.sv
// One registered tree level: NIN segments in, NIN/2 out.
module segmin_level
    import segmin_pkg::*;
#(
    parameter int NIN = 2,
    localparam int NOUT = NIN / 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       vld_i,
    input  esz_e                       sz_i,
    input  logic                       dn_i,
    input  logic                       inv_i,
    input  logic [NIN-1:0][SEG_W-1:0]  dat_i,
    output logic                       vld_o,
    output esz_e                       sz_o,
    output logic                       dn_o,
    output logic                       inv_o,
    output logic [NOUT-1:0][SEG_W-1:0] dat_o
);

    typedef struct packed {
        logic                       vld;
        esz_e                       sz;
        logic                       dn;
        logic                       inv;
        logic [NOUT-1:0][SEG_W-1:0] dat;
    } lvl_t;

    lvl_t                       st_d, st_q;
    logic [NOUT-1:0][SEG_W-1:0] pair_y;
    logic [NOUT-1:0]            pair_inv;

    for (genvar j = 0; j < NOUT; j++) begin : g_pair
        segmin_node u_node (
            .sz (sz_i),
            .dn (dn_i),
            .a  (dat_i[2*j]),
            .b  (dat_i[2*j+1]),
            .y  (pair_y[j]),
            .inv(pair_inv[j])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = vld_i;
        if (vld_i) begin
            st_d.sz  = sz_i;
            st_d.dn  = dn_i;
            st_d.inv = inv_i | (|pair_inv);
            st_d.dat = pair_y;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o = st_q.vld;
    assign sz_o  = st_q.sz;
    assign dn_o  = st_q.dn;
    assign inv_o = st_q.inv;
    assign dat_o = st_q.dat;

endmodule

// File: rtl/segmin_reduce.sv
module segmin_reduce
    import segmin_pkg::*;
#(
    parameter int VLEN = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VLEN-1:0]   vec,
    input  logic [VLEN/8-1:0] pred,
    input  logic [1:0]        size,
    input  logic              dflt_nan,
    output logic [127:0]      result,
    output logic              done,
    output logic              invalid
);

    localparam int NSEG = VLEN / SEG_W;
    localparam int LVLS = $clog2(NSEG);

    typedef struct packed {
        logic                       vld;
        esz_e                       sz;
        logic                       dn;
        logic [NSEG-1:0][SEG_W-1:0] dat;
    } in_t;

    in_t                        s0_d, s0_q;
    logic [NSEG-1:0][SEG_W-1:0] masked;
    logic                       accept;

    assign accept = start && (size != 2'b00);

    segmin_mask #(.NSEG(NSEG)) u_mask (
        .vec  (vec),
        .pred (pred),
        .sz   (esz_e'(size)),
        .seg_o(masked)
    );

    always_comb begin
        s0_d     = s0_q;
        s0_d.vld = accept;
        if (accept) begin
            s0_d.sz  = esz_e'(size);
            s0_d.dn  = dflt_nan;
            s0_d.dat = masked;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s0_q <= '0;
        else        s0_q <= s0_d;
    end

    for (genvar i = 0; i < LVLS; i++) begin : g_lvl
        localparam int NIN  = NSEG >> i;
        localparam int NOUT = NIN / 2;
        logic                       vld_o;
        esz_e                       sz_o;
        logic                       dn_o;
        logic                       inv_o;
        logic [NOUT-1:0][SEG_W-1:0] dat_o;
        if (i == 0) begin : g_first
            segmin_level #(.NIN(NIN)) u_lvl (
                .clk(clk), .rst_n(rst_n),
                .vld_i(s0_q.vld), .sz_i(s0_q.sz), .dn_i(s0_q.dn), .inv_i(1'b0),
                .dat_i(s0_q.dat),
                .vld_o(vld_o), .sz_o(sz_o), .dn_o(dn_o), .inv_o(inv_o), .dat_o(dat_o));
        end else begin : g_next
            segmin_level #(.NIN(NIN)) u_lvl (
                .clk(clk), .rst_n(rst_n),
                .vld_i(g_lvl[i-1].vld_o), .sz_i(g_lvl[i-1].sz_o),
                .dn_i(g_lvl[i-1].dn_o), .inv_i(g_lvl[i-1].inv_o),
                .dat_i(g_lvl[i-1].dat_o),
                .vld_o(vld_o), .sz_o(sz_o), .dn_o(dn_o), .inv_o(inv_o), .dat_o(dat_o));
        end
    end

    if (LVLS == 0) begin : g_out
        assign result  = s0_q.dat[0];
        assign done    = s0_q.vld;
        assign invalid = 1'b0;
    end else begin : g_out
        assign result  = g_lvl[LVLS-1].dat_o[0];
        assign done    = g_lvl[LVLS-1].vld_o;
        assign invalid = g_lvl[LVLS-1].inv_o;
    end

endmodule

// File: rtl/segmin_reduce_chk.sv
module segmin_reduce_chk #(
    parameter int VLEN = 512
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [VLEN-1:0]   vec,
    input logic [VLEN/8-1:0] pred,
    input logic [1:0]        size,
    input logic              dflt_nan,
    input logic [127:0]      result,
    input logic              done,
    input logic              invalid
);

    localparam int LAT = $clog2(VLEN / 128) + 1;

    logic       acc_sr [LAT];
    logic       dn_sr  [LAT];
    logic [1:0] sz_sr  [LAT];
    logic       nan_quiet, nan_canon;
    logic [15:0] h;
    logic [31:0] f;
    logic [63:0] d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < LAT; k++) begin
                acc_sr[k] <= 1'b0;
                dn_sr[k]  <= 1'b0;
                sz_sr[k]  <= 2'b00;
            end
        end else begin
            for (int k = LAT - 1; k > 0; k--) begin
                acc_sr[k] <= acc_sr[k-1];
                dn_sr[k]  <= dn_sr[k-1];
                sz_sr[k]  <= sz_sr[k-1];
            end
            acc_sr[0] <= start && (size != 2'b00);
            dn_sr[0]  <= dflt_nan;
            sz_sr[0]  <= size;
        end
    end

    always_comb begin
        nan_quiet = 1'b1;
        nan_canon = 1'b1;
        h = '0;
        f = '0;
        d = '0;
        case (sz_sr[LAT-1])
            2'b01: for (int k = 0; k < 8; k++) begin
                h = result[16*k +: 16];
                if (&h[14:10] && |h[9:0]) begin
                    if (!h[9]) nan_quiet = 1'b0;
                    if (h != 16'h7E00) nan_canon = 1'b0;
                end
            end
            2'b10: for (int k = 0; k < 4; k++) begin
                f = result[32*k +: 32];
                if (&f[30:23] && |f[22:0]) begin
                    if (!f[22]) nan_quiet = 1'b0;
                    if (f != 32'h7FC0_0000) nan_canon = 1'b0;
                end
            end
            2'b11: for (int k = 0; k < 2; k++) begin
                d = result[64*k +: 64];
                if (&d[62:52] && |d[51:0]) begin
                    if (!d[51]) nan_quiet = 1'b0;
                    if (d != 64'h7FF8_0000_0000_0000) nan_canon = 1'b0;
                end
            end
            default: ;
        endcase
    end

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done == acc_sr[LAT-1]); // R6

    AST_ILLEGAL_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> sz_sr[LAT-1] != 2'b00); // R7

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(result) && $stable(invalid))); // R8

    AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> nan_quiet); // R4

    AST_NAN_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dn_sr[LAT-1]) |-> nan_canon); // R4

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!done && !invalid)); // R10

endmodule

bind segmin_reduce segmin_reduce_chk #(.VLEN(VLEN)) u_chk (.*);

// File: tb/segmin_reduce_tb_top.sv
module segmin_reduce_tb_top;

    localparam int VLEN = 512;
    localparam int LAT  = 3;

    typedef struct packed {
        logic [VLEN-1:0]   vec;
        logic [VLEN/8-1:0] pred;
        logic [1:0]        sz;
        logic              dn;
        logic [127:0]      exp;
        logic              inv;
        logic [3:0]        req;
    } row_t;

    localparam row_t TBL [8] = '{
        // R1 R3: single precision, signed zeros, qNaN against numbers
        '{ {128'h3F000000_00000000_7FC00000_C0000000, 128'hBF800000_00000000_7FC00000_3F800000,
            128'h40000000_80000000_3F000000_40400000, 128'h3F800000_00000000_7FC00000_40000000},
           64'hFFFF_FFFF_FFFF_FFFF, 2'b10, 1'b0,
           128'hBF800000_80000000_3F000000_C0000000, 1'b0, 4'd1 },
        // R4 R5: sNaN made quiet, then beaten by a number; NaN order kept
        '{ {128'h40000000_40000000_7FC00005_3F800000, 128'h40000000_40000000_7FC00004_3F800000,
            128'h40000000_40000000_7F800003_3F800000, 128'h40000000_40000000_7FC00002_7F800001},
           64'hFFFF_FFFF_FFFF_FFFF, 2'b10, 1'b0,
           128'h40000000_40000000_7FC00003_3F800000, 1'b1, 4'd4 },
        // R4 R5: same input, default-NaN mode
        '{ {128'h40000000_40000000_7FC00005_3F800000, 128'h40000000_40000000_7FC00004_3F800000,
            128'h40000000_40000000_7F800003_3F800000, 128'h40000000_40000000_7FC00002_7F800001},
           64'hFFFF_FFFF_FFFF_FFFF, 2'b10, 1'b1,
           128'h40000000_40000000_7FC00000_3F800000, 1'b1, 4'd5 },
        // R2: half precision, partial predicate, odd-byte-only bits ignored
        '{ {{8{16'hC200}}, {8{16'hBC00}}, {8{16'h3C00}}, {8{16'h4000}}},
           {16'hAAAA, 16'h00FF, 16'hFFFF, 16'hFFFF}, 2'b01, 1'b0,
           {{4{16'h3C00}}, {4{16'hBC00}}}, 1'b0, 4'd2 },
        // R3: double precision, infinities and signed zero
        '{ {128'h3FF0000000000000_8000000000000000, 128'hFFF0000000000000_7FF8000000000000,
            128'h3FF0000000000000_3FF0000000000000, 128'h3FF0000000000000_7FF0000000000000},
           64'hFFFF_FFFF_FFFF_FFFF, 2'b11, 1'b1,
           128'hFFF0000000000000_8000000000000000, 1'b0, 4'd3 },
        // R9: nothing active, single precision
        '{ {4{128'h3F800000_3F800000_3F800000_3F800000}},
           64'h0, 2'b10, 1'b0, {4{32'h7FC00000}}, 1'b0, 4'd9 },
        // R9 R2: only odd bytes set, half precision, default-NaN mode
        '{ {4{128'h0}}, 64'hAAAA_AAAA_AAAA_AAAA, 2'b01, 1'b1,
           {8{16'h7E00}}, 1'b0, 4'd9 },
        // R4 R5: double, sNaN first, inactive top segment
        '{ {128'h0000000000000000_7FF8000000000009, 128'h0000000000000000_7FF8000000000002,
            128'h0000000000000000_7FF8000000000000, 128'h0000000000000000_7FF0000000000001},
           {16'h0000, 16'hFFFF, 16'hFFFF, 16'hFFFF}, 2'b11, 1'b0,
           128'h0000000000000000_7FF8000000000001, 1'b1, 4'd4 }
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start;
    logic [VLEN-1:0]   vec;
    logic [VLEN/8-1:0] pred;
    logic [1:0]        size;
    logic              dflt_nan;
    logic [127:0]      result;
    logic              done;
    logic              invalid;

    int  n_chk = 0;
    int  n_err = 0;
    bit  ended = 1'b0;

    always #5 clk = ~clk;

    segmin_reduce #(.VLEN(VLEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .vec(vec), .pred(pred),
        .size(size), .dflt_nan(dflt_nan), .result(result), .done(done),
        .invalid(invalid));

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    task automatic drive_row(input int i);
        vec      = TBL[i].vec;
        pred     = TBL[i].pred;
        size     = TBL[i].sz;
        dflt_nan = TBL[i].dn;
        start    = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got %0d expected 0 hung cycles", 1);
        finish_run();
    end

    initial begin
        int cnt;
        logic [127:0] last_res;
        logic         last_inv;
        rst_n = 1'b0; start = 1'b0; vec = '0; pred = '0; size = 2'b10; dflt_nan = 1'b0;
        repeat (3) @(negedge clk);
        // R10: outputs cleared by reset
        chk(result == '0, "R10", "reset result", result, '0);
        chk(!done, "R10", "reset done", {127'b0, done}, '0);
        chk(!invalid, "R10", "reset invalid", {127'b0, invalid}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R1 R2 R3 R4 R5 R6 R9
        for (int i = 0; i < 8; i++) begin
            drive_row(i);
            @(negedge clk);
            start = 1'b0;
            cnt = 1;
            while (!done && cnt < 20) begin
                @(negedge clk);
                cnt++;
            end
            chk(cnt == LAT, "R6", $sformatf("latency row %0d", i), 128'(cnt), 128'(LAT));
            chk(result == TBL[i].exp, $sformatf("R%0d", TBL[i].req),
                $sformatf("result row %0d", i), result, TBL[i].exp);
            chk(invalid == TBL[i].inv, "R5", $sformatf("invalid row %0d", i),
                {127'b0, invalid}, {127'b0, TBL[i].inv});
            @(negedge clk);
            chk(!done, "R6", "done is one cycle", {127'b0, done}, '0);
        end
        last_res = TBL[7].exp;
        last_inv = TBL[7].inv;

        // R8: outputs hold while idle
        repeat (5) @(negedge clk);
        chk(result == last_res, "R8", "idle hold result", result, last_res);
        chk(invalid == last_inv, "R8", "idle hold invalid", {127'b0, invalid}, {127'b0, last_inv});

        // R7: illegal size code 00 is dropped
        drive_row(0);
        size = 2'b00;
        @(negedge clk);
        start = 1'b0;
        cnt = 0;
        for (int k = 0; k < LAT + 3; k++) begin
            if (done) cnt++;
            @(negedge clk);
        end
        chk(cnt == 0, "R7", "no done after illegal start", 128'(cnt), '0);
        chk(result == last_res, "R7", "result kept", result, last_res);
        chk(invalid == last_inv, "R7", "invalid kept", {127'b0, invalid}, {127'b0, last_inv});

        // R6: back-to-back starts complete in order
        drive_row(0);
        @(negedge clk);
        drive_row(4);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(done && result == TBL[0].exp, "R6", "first of pair", result, TBL[0].exp);
        @(negedge clk);
        chk(done && result == TBL[4].exp, "R6", "second of pair", result, TBL[4].exp);
        @(negedge clk);
        chk(!done, "R6", "pair ends", {127'b0, done}, '0);

        // R5: invalid returns to 0 after a clean operation following a flagged one
        drive_row(1);
        @(negedge clk);
        drive_row(3);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(done && invalid, "R5", "flagged op", {127'b0, invalid}, 128'd1);
        @(negedge clk);
        chk(done && !invalid && result == TBL[3].exp, "R5", "clean op after flagged",
            {127'b0, invalid}, '0);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule